// File: doc/BRIEF.md
# Sprite Table Copy Engine

This block copies a fixed 160-byte sprite attribute table out of ordinary memory and into the sprite attribute window at 0xFE00. Software starts a copy by writing a single byte to the control register at I/O address 0xFF46. That byte becomes the upper eight bits of a page-aligned source address. The engine then walks the source index from 0 up to 159. For each index it fetches one byte through a request/valid read port and stores it at 0xFE00 plus that index.

Reads are paced at an even cadence, so a full copy takes 671 cycles at normal speed. When the double-speed input is set, the copy takes half that time. While the copy runs, a busy flag is high. Any CPU access outside the high scratch RAM (0xFF80–0xFFFE) is flagged as blocked, so the surrounding bus logic can stall it. A new valid write during a copy restarts the copy from index 0 at the new page.

Top module: `sprd_dma`

## Requirements
- R1: A write of page P (P ≤ 0xDF) to address 0xFF46 sets busy on the next cycle. The first read address is {P, 0x00}.
- R2: A write to any other address, or a write of a page above 0xDF, is ignored. If the engine is idle it stays idle with no read request. If a copy is running, that copy carries on unchanged.
- R3: Byte index i is read from {P, i}. The returned data is written to 0xFE00 + i. Indexes are written in ascending order.
- R4: Each trigger writes exactly 160 bytes. Busy falls on the cycle after the 160th write.
- R5: At normal speed, the first read request comes 33 cycles after busy rises, and requests are then 4 cycles apart. With a memory that answers on the next cycle, busy lasts 671 cycles.
- R6: With double speed set, the first request comes after 16 cycles and requests are 2 cycles apart. Busy lasts 336 cycles.
- R7: mem_req is a one-cycle pulse. No new request is issued while a read is outstanding. A late answer stalls the sequence, and the next request follows one cycle after the answer.
- R8: cpu_block is high exactly when busy is high, cpu_acc is high, and cpu_addr lies outside 0xFF80–0xFFFE.
- R9: A valid trigger during a copy restarts the copy from index 0 at the new page, with the full 160 bytes and full timing.
- R10: After reset, busy, mem_req, oam_we and cpu_block are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | CPU register write strobe |
| cfg_addr | input | 16 | CPU register write address |
| cfg_wdata | input | 8 | CPU register write data (source page) |
| double_speed | input | 1 | Double-rate pacing when high |
| cpu_acc | input | 1 | CPU is making a memory access this cycle |
| cpu_addr | input | 16 | Address of that CPU access |
| cpu_block | output | 1 | CPU access must be stalled |
| mem_req | output | 1 | Read request pulse |
| mem_addr | output | 16 | Read address |
| mem_valid | input | 1 | Read data valid |
| mem_rdata | input | 8 | Read data |
| oam_we | output | 1 | Attribute memory write strobe |
| oam_addr | output | 16 | Attribute memory write address |
| oam_wdata | output | 8 | Attribute memory write data |
| busy | output | 1 | Copy in progress |

## Verification
The copy is exercised over several source pages, including 0x00, 0xDF and a mid-range page, at both speeds. This shows that the page byte reaches the upper address bits untouched, and that the lead and gap timers reload with the right value for each speed. Pages 0xE0 and 0xFF, and a write to a neighbouring register address, check the acceptance filter. A memory model answering five cycles late separates the stall path from the fixed cadence. A restart during a copy, with an out-of-range write inserted before it, shows that only valid triggers reset the index. The lockout is probed on both edges of the scratch RAM range and with no access pending.

// File: rtl/sprd_pkg.sv
package sprd_pkg;
  localparam logic [15:0] REG_ADDR = 16'hFF46;
  localparam logic [15:0] DST_BASE = 16'hFE00;
  localparam logic [15:0] HRAM_LO  = 16'hFF80;
  localparam logic [15:0] HRAM_HI  = 16'hFFFE;
  localparam logic [7:0]  PAGE_MAX = 8'hDF;

  function automatic logic [15:0] src_addr(input logic [7:0] page, input logic [7:0] idx);
    return {page, idx};
  endfunction

  function automatic logic [15:0] dst_addr(input logic [7:0] idx);
    return DST_BASE + {8'h00, idx};
  endfunction

  function automatic logic page_ok(input logic [7:0] page);
    return page <= PAGE_MAX;
  endfunction

  function automatic logic in_hram(input logic [15:0] a);
    return (a >= HRAM_LO) && (a <= HRAM_HI);
  endfunction
endpackage

// File: rtl/sprd_pacer.sv
module sprd_pacer #(
  parameter int SLOT_CYCLES = 4,
  parameter int LEAD_CYCLES = 33
) (
  input  logic clk,
  input  logic rst_n,
  input  logic launch,
  input  logic active,
  input  logic pending,
  input  logic double_speed,
  output logic fire
);
  localparam int TMR_W = $clog2(LEAD_CYCLES + SLOT_CYCLES + 1);
  localparam logic [TMR_W-1:0] LEAD_N = TMR_W'(LEAD_CYCLES);
  localparam logic [TMR_W-1:0] LEAD_D = TMR_W'(LEAD_CYCLES / 2);
  localparam logic [TMR_W-1:0] GAP_N  = TMR_W'(SLOT_CYCLES - 1);
  localparam logic [TMR_W-1:0] GAP_D  = TMR_W'(SLOT_CYCLES / 2 - 1);

  logic [TMR_W-1:0] tmr;

  assign fire = active && !pending && (tmr == '0) && !launch;

  always_ff @(posedge clk) begin
    if (!rst_n)         tmr <= '0;
    else if (launch)    tmr <= double_speed ? LEAD_D : LEAD_N;
    else if (fire)      tmr <= double_speed ? GAP_D : GAP_N;
    else if (tmr != '0) tmr <= tmr - 1'b1;
  end
endmodule

// File: rtl/sprd_seq.sv
module sprd_seq #(
  parameter int NUM_BYTES = 160
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        launch,
  input  logic [7:0]  launch_page,
  input  logic        fire,
  input  logic        mem_valid,
  input  logic [7:0]  mem_rdata,
  output logic        active,
  output logic        pending,
  output logic [15:0] mem_addr,
  output logic        oam_we,
  output logic [15:0] oam_addr,
  output logic [7:0]  oam_wdata,
  output logic        last_wr
);
  localparam logic [7:0] LAST_IDX = 8'(NUM_BYTES - 1);

  logic [7:0] page;
  logic [7:0] idx;
  logic       byte_done;

  assign byte_done = pending && mem_valid && !launch;
  assign last_wr   = byte_done && (idx == LAST_IDX);
  assign mem_addr  = sprd_pkg::src_addr(page, idx);
  assign oam_addr  = sprd_pkg::dst_addr(idx);
  assign oam_wdata = mem_rdata;
  assign oam_we    = byte_done;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active  <= 1'b0;
      pending <= 1'b0;
      page    <= '0;
      idx     <= '0;
    end else if (launch) begin
      active  <= 1'b1;
      pending <= 1'b0;
      page    <= launch_page;
      idx     <= '0;
    end else if (byte_done) begin
      pending <= 1'b0;
      idx     <= idx + 1'b1;
      if (last_wr) active <= 1'b0;
    end else if (fire) begin
      pending <= 1'b1;
    end
  end
endmodule

// File: rtl/sprd_lock.sv
module sprd_lock (
  input  logic        active,
  input  logic        cpu_acc,
  input  logic [15:0] cpu_addr,
  output logic        cpu_block
);
  assign cpu_block = active && cpu_acc && !sprd_pkg::in_hram(cpu_addr);
endmodule

// File: rtl/sprd_dma.sv
module sprd_dma #(
  parameter int NUM_BYTES   = 160,
  parameter int SLOT_CYCLES = 4,
  parameter int LEAD_CYCLES = 33
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cfg_we,
  input  logic [15:0] cfg_addr,
  input  logic [7:0]  cfg_wdata,
  input  logic        double_speed,
  input  logic        cpu_acc,
  input  logic [15:0] cpu_addr,
  output logic        cpu_block,
  output logic        mem_req,
  output logic [15:0] mem_addr,
  input  logic        mem_valid,
  input  logic [7:0]  mem_rdata,
  output logic        oam_we,
  output logic [15:0] oam_addr,
  output logic [7:0]  oam_wdata,
  output logic        busy
);
  logic launch;
  logic fire;
  logic active;
  logic pending;
  logic last_wr;

  assign launch  = cfg_we && (cfg_addr == sprd_pkg::REG_ADDR) && sprd_pkg::page_ok(cfg_wdata);
  assign mem_req = fire;
  assign busy    = active;

  sprd_pacer #(.SLOT_CYCLES(SLOT_CYCLES), .LEAD_CYCLES(LEAD_CYCLES)) u_pacer (
    .clk(clk), .rst_n(rst_n), .launch(launch), .active(active),
    .pending(pending), .double_speed(double_speed), .fire(fire)
  );

  sprd_seq #(.NUM_BYTES(NUM_BYTES)) u_seq (
    .clk(clk), .rst_n(rst_n), .launch(launch), .launch_page(cfg_wdata),
    .fire(fire), .mem_valid(mem_valid), .mem_rdata(mem_rdata),
    .active(active), .pending(pending), .mem_addr(mem_addr),
    .oam_we(oam_we), .oam_addr(oam_addr), .oam_wdata(oam_wdata),
    .last_wr(last_wr)
  );

  sprd_lock u_lock (
    .active(active), .cpu_acc(cpu_acc), .cpu_addr(cpu_addr), .cpu_block(cpu_block)
  );
endmodule

// File: rtl/sprd_dma_chk.sv
module sprd_dma_chk (
  input logic clk,
  input logic rst_n,
  input logic launch,
  input logic last_wr,
  input logic busy,
  input logic mem_req,
  input logic oam_we,
  input logic cpu_block
);
  // R1
  launch_busy_chk: assert property (@(posedge clk) disable iff (!rst_n) launch |=> busy);
  // R7
  req_single_chk: assert property (@(posedge clk) disable iff (!rst_n) mem_req |=> !mem_req);
  // R4
  last_drop_chk: assert property (@(posedge clk) disable iff (!rst_n) (last_wr && !launch) |=> !busy);
  // R4
  fall_after_write_chk: assert property (@(posedge clk) disable iff (!rst_n) $fell(busy) |-> $past(oam_we));
  // R8
  block_busy_chk: assert property (@(posedge clk) disable iff (!rst_n) cpu_block |-> busy);
  // R2
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n) !busy |-> (!mem_req && !oam_we));
endmodule

bind sprd_dma sprd_dma_chk u_chk (
  .clk(clk), .rst_n(rst_n), .launch(launch), .last_wr(last_wr),
  .busy(busy), .mem_req(mem_req), .oam_we(oam_we), .cpu_block(cpu_block)
);

// File: tb/test_sprd_dma.sv
module test_sprd_dma;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [15:0] cfg_addr = '0;
  logic [7:0]  cfg_wdata = '0;
  logic        double_speed = 1'b0;
  logic        cpu_acc = 1'b0;
  logic [15:0] cpu_addr = '0;
  logic        cpu_block, mem_req, oam_we, busy;
  logic [15:0] mem_addr, oam_addr;
  logic [7:0]  oam_wdata;
  logic        mem_valid;
  logic [7:0]  mem_rdata;

  int errors = 0;
  int checks = 0;
  int lat = 1;

  // monitor statistics
  int bcyc = 0, nreq = 0, first_req = -1, last_req = 0, gmin = 9999, gmax = 0;
  int widx = 0, wbad = 0;
  logic [7:0] epage = '0;

  always #10 clk = ~clk;

  sprd_dma i_sprd_dma (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
    .double_speed(double_speed), .cpu_acc(cpu_acc), .cpu_addr(cpu_addr), .cpu_block(cpu_block),
    .mem_req(mem_req), .mem_addr(mem_addr), .mem_valid(mem_valid), .mem_rdata(mem_rdata),
    .oam_we(oam_we), .oam_addr(oam_addr), .oam_wdata(oam_wdata), .busy(busy)
  );

  function automatic logic [7:0] mfun(input logic [15:0] a);
    return 8'((a[7:0] + 8'd17 * a[15:8]) ^ 8'h3C);
  endfunction

  // {page, dbl, busy_len, first_req, gap}
  localparam logic [47:0] VECS [0:5] = '{
    {8'hC0, 8'd0, 16'd671, 8'd33, 8'd4},
    {8'h00, 8'd0, 16'd671, 8'd33, 8'd4},
    {8'hDF, 8'd1, 16'd336, 8'd16, 8'd2},
    {8'h81, 8'd1, 16'd336, 8'd16, 8'd2},
    {8'hE0, 8'd0, 16'd0,   8'd0,  8'd0},
    {8'hFF, 8'd1, 16'd0,   8'd0,  8'd0}
  };

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // memory model: answers lat cycles after a request
  initial begin
    logic [15:0] maddr;
    int mcnt;
    maddr = '0; mcnt = 0;
    mem_valid = 1'b0; mem_rdata = '0;
    forever begin
      @(posedge clk); #2;
      mem_valid = 1'b0;
      if (mcnt > 0) begin
        mcnt--;
        if (mcnt == 0) begin mem_valid = 1'b1; mem_rdata = mfun(maddr); end
      end
      if (mem_req) begin maddr = mem_addr; mcnt = lat; end
    end
  end

  // monitor
  initial forever begin
    @(negedge clk);
    if (busy) begin
      if (mem_req) begin
        if (nreq == 0) first_req = bcyc;
        else begin
          if (bcyc - last_req < gmin) gmin = bcyc - last_req;
          if (bcyc - last_req > gmax) gmax = bcyc - last_req;
        end
        last_req = bcyc;
        nreq++;
      end
      if (oam_we) begin
        if (oam_addr !== 16'hFE00 + 16'(widx) || oam_wdata !== mfun({epage, 8'(widx)})) wbad++;
        widx++;
      end
      bcyc++;
    end
  end

  task automatic clear_stats(input logic [7:0] pg);
    bcyc = 0; nreq = 0; first_req = -1; last_req = 0; gmin = 9999; gmax = 0;
    widx = 0; wbad = 0; epage = pg;
  endtask

  // one register write; stats cleared after the edge that sees it
  task automatic reg_write(input logic [15:0] a, input logic [7:0] d, input bit clr);
    @(posedge clk); #5;
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(posedge clk); #5;
    cfg_we = 1'b0;
    if (clr) clear_stats(d);
  endtask

  task automatic wait_idle();
    for (int k = 0; k < 3000 && busy; k++) @(negedge clk);
    @(negedge clk);
  endtask

  initial begin
    #(20 * 150000);
    check(1'b0, "watchdog", 0, 1);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    cpu_acc = 1'b1; cpu_addr = 16'hC000;
    repeat (3) @(posedge clk);
    #5 rst_n = 1'b1;
    @(negedge clk);
    // R10 reset state
    check(busy == 1'b0, "R10 busy", int'(busy), 0);
    check(mem_req == 1'b0, "R10 mem_req", int'(mem_req), 0);
    check(oam_we == 1'b0, "R10 oam_we", int'(oam_we), 0);
    check(cpu_block == 1'b0, "R10 cpu_block", int'(cpu_block), 0);
    cpu_acc = 1'b0;

    // table-driven transfers: R1 R3 R4 R5 R6 R2
    foreach (VECS[v]) begin
      logic [7:0] pg; int blen, frq, gap;
      pg = VECS[v][47:40]; blen = int'(VECS[v][31:16]);
      frq = int'(VECS[v][15:8]); gap = int'(VECS[v][7:0]);
      double_speed = VECS[v][32];
      lat = 1;
      clear_stats(pg);
      reg_write(16'hFF46, pg, 1'b1);
      check(busy == (blen != 0), "R1 busy after write", int'(busy), int'(blen != 0));
      wait_idle();
      if (blen != 0) begin
        check(bcyc == blen, double_speed ? "R6 busy length" : "R5 busy length", bcyc, blen);
        check(first_req == frq, double_speed ? "R6 first request" : "R5 first request", first_req, frq);
        check(gmin == gap && gmax == gap, double_speed ? "R6 request gap" : "R5 request gap", gmax, gap);
        check(widx == 160, "R4 write count", widx, 160);
        check(wbad == 0, "R3 address/data", wbad, 0);
      end else begin
        check(bcyc == 0 && nreq == 0, "R2 bad page ignored", bcyc + nreq, 0);
      end
    end

    // R2 wrong register address
    double_speed = 1'b0;
    clear_stats(8'h40);
    reg_write(16'hFF47, 8'h40, 1'b0);
    repeat (40) @(negedge clk);
    check(bcyc == 0 && nreq == 0, "R2 other address ignored", bcyc + nreq, 0);

    // R7 late memory
    lat = 5;
    reg_write(16'hFF46, 8'h12, 1'b1);
    wait_idle();
    check(bcyc == 993, "R7 stalled busy length", bcyc, 993);
    check(gmin == 6 && gmax == 6, "R7 stalled gap", gmax, 6);
    check(widx == 160 && wbad == 0, "R7 stalled data", wbad, 0);
    lat = 1;

    // R8 lockout during a copy
    reg_write(16'hFF46, 8'h30, 1'b1);
    @(negedge clk);
    cpu_acc = 1'b1; cpu_addr = 16'hC000; #1;
    check(cpu_block == 1'b1, "R8 low memory", int'(cpu_block), 1);
    cpu_addr = 16'hFF80; #1;
    check(cpu_block == 1'b0, "R8 hram low edge", int'(cpu_block), 0);
    cpu_addr = 16'hFFFE; #1;
    check(cpu_block == 1'b0, "R8 hram high edge", int'(cpu_block), 0);
    cpu_addr = 16'hFF7F; #1;
    check(cpu_block == 1'b1, "R8 below hram", int'(cpu_block), 1);
    cpu_addr = 16'hFFFF; #1;
    check(cpu_block == 1'b1, "R8 above hram", int'(cpu_block), 1);
    cpu_acc = 1'b0; cpu_addr = 16'hC000; #1;
    check(cpu_block == 1'b0, "R8 no access", int'(cpu_block), 0);
    wait_idle();
    cpu_acc = 1'b1; #1;
    check(cpu_block == 1'b0, "R8 idle", int'(cpu_block), 0);
    cpu_acc = 1'b0;

    // R9 restart, with an ignored out-of-range write first (R2)
    reg_write(16'hFF46, 8'h20, 1'b1);
    repeat (60) @(negedge clk);
    reg_write(16'hFF46, 8'hE5, 1'b0);
    repeat (40) @(negedge clk);
    check(wbad == 0 && widx > 10, "R2 bad page during copy", wbad, 0);
    reg_write(16'hFF46, 8'h40, 1'b1);
    wait_idle();
    check(bcyc == 671, "R9 restart length", bcyc, 671);
    check(first_req == 33, "R9 restart lead", first_req, 33);
    check(widx == 160 && wbad == 0, "R9 restart data", wbad, 0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule